// File: doc/BRIEF.md
# MSI-X Mask and Pending Controller

This block gates the MSI-X interrupts of one PCI function. It holds a small vector table. Each entry has a 64-bit message address, a 32-bit message data word and a mask bit. It also holds one pending bit per vector and the function-wide mask bit. The device core raises a one-cycle request on any vector. A request whose vector may fire turns into a message on a valid/ready output that carries the vector number, address and data. A request whose vector may not fire is kept as a pending bit.

Every request first sets the vector's pending bit. A selector then offers the lowest-numbered pending vector that is masked neither on its own nor by the function mask. The pending bit clears on the cycle the message is accepted. With this structure, clearing a vector mask or clearing the function mask replays the held vectors automatically, in ascending order, one per accepted message. Software reaches the table, the pending array and the control word through a single-cycle register port with 32-bit and 64-bit accesses. Reads are combinational.

Top module: `msix_gate`

## Requirements
- R1: After reset, every vector's mask reads 1, the function mask reads 0, every pending bit reads 0 and `msg_valid_o` is low.
- R2: Table space (`reg_space_i`=0): entry n starts at byte offset 16n. A 32-bit access at +0x0, +0x4 or +0x8 writes and reads address-low, address-high and data. At +0xC the access uses the vector control word, whose bit 0 is the vector mask and whose other bits read 0.
- R3: A 64-bit table access at +0x0 covers address-low (low half) and address-high (high half). At +0x8 it covers data (low half) and the vector mask (bit 32). Either write goes through the same unmask path as a 32-bit control write.
- R4: Table writes at any other entry offset, or to an entry index of NUM_VEC or above, change nothing, and such reads return 0. Writes to the pending space (`reg_space_i`=1) and to space 3 change nothing.
- R5: A request on a masked vector, or on any vector while the function mask is set, produces no message and sets that vector's pending bit. Pending bit n reads in pending word n/64 (byte offset 8·(n/64)) at bit n%64.
- R6: A request on an unmasked vector while the function mask is clear produces one message with vector n, address {address-high, address-low} and the entry's data. The pending bit reads 1 until that message is accepted.
- R7: Clearing a vector's mask while the function mask is clear and its pending bit is set sends that vector's message and then clears the pending bit.
- R8: Clearing a vector's mask while the function mask is set sends nothing, and the pending bit stays set.
- R9: The function mask is bit 14 of the control word (`reg_space_i`=2, offset ignored). When it goes from 1 to 0, every pending vector that is not masked on its own is sent in ascending index order. Pending vectors that are still masked stay pending.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, the vector, address and data hold steady. A pending bit clears only on the cycle its message is accepted.
- R11: Several requests on one vector before its message is accepted merge into a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_VEC | Per-vector interrupt request, one bit per cycle of request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_space_i | input | 2 | 0 table, 1 pending array, 2 control word |
| reg_off_i | input | OFF_W | Byte offset within the selected space |
| reg_wide_i | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the current space and offset |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_vec_o | output | VEC_W | Vector number of the offered message |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The embedded properties check on every cycle that an offered message holds steady under backpressure. They check that an offered vector is always pending, that a request always leaves its pending bit set, and that a pending bit never drops except on acceptance. They also check that a free output never takes a new message while the function mask is set. The bench scenarios show the parts no single-cycle property can reach: the ascending replay order after the function mask clears, the difference between unmasking with and without the function mask, the 64-bit control path, and the merging of repeated requests. They also cover the register map, including the ignored offsets.

// File: rtl/msix_gate_pkg.sv
package msix_gate_pkg;
  localparam int unsigned FMASK_BIT     = 14;
  localparam int unsigned PBA_WORD_BITS = 64;

  typedef enum logic [1:0] {
    SPACE_TABLE = 2'd0,
    SPACE_PBA   = 2'd1,
    SPACE_CTRL  = 2'd2,
    SPACE_NONE  = 2'd3
  } reg_space_e;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_gate_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned OFF_W   = 8,
  localparam int unsigned IDX_W  = OFF_W - 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      wide_i,
  input  logic [OFF_W-1:0]          off_i,
  input  logic [63:0]               wdata_i,
  output logic [63:0]               rdata_o,
  output vec_entry_t [NUM_VEC-1:0]  tbl_o,
  output logic [NUM_VEC-1:0]        vmask_o
);
  logic [IDX_W-1:0] idx;
  logic [3:0]       sub;

  assign idx = off_i[OFF_W-1:4];
  assign sub = off_i[3:0];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    vec_entry_t ent_q;
    logic       hit;

    assign hit = wr_i && (idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '{addr_lo: '0, addr_hi: '0, data: '0, mask: 1'b1};
      end else if (hit) begin
        if (!wide_i) begin
          case (sub)
            4'h0: ent_q.addr_lo <= wdata_i[31:0];
            4'h4: ent_q.addr_hi <= wdata_i[31:0];
            4'h8: ent_q.data    <= wdata_i[31:0];
            4'hC: ent_q.mask    <= wdata_i[0];
            default: ;
          endcase
        end else begin
          case (sub)
            4'h0: begin
              ent_q.addr_lo <= wdata_i[31:0];
              ent_q.addr_hi <= wdata_i[63:32];
            end
            4'h8: begin
              ent_q.data <= wdata_i[31:0];
              ent_q.mask <= wdata_i[32];
            end
            default: ;
          endcase
        end
      end
    end

    assign tbl_o[g]   = ent_q;
    assign vmask_o[g] = ent_q.mask;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (idx == IDX_W'(i)) begin
        if (!wide_i) begin
          case (sub)
            4'h0: rdata_o = {32'h0, tbl_o[i].addr_lo};
            4'h4: rdata_o = {32'h0, tbl_o[i].addr_hi};
            4'h8: rdata_o = {32'h0, tbl_o[i].data};
            4'hC: rdata_o = {63'h0, tbl_o[i].mask};
            default: rdata_o = '0;
          endcase
        end else begin
          case (sub)
            4'h0: rdata_o = {tbl_o[i].addr_hi, tbl_o[i].addr_lo};
            4'h8: rdata_o = {31'h0, tbl_o[i].mask, tbl_o[i].data};
            default: rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array
  import msix_gate_pkg::*;
#(
  parameter int unsigned NUM_VEC   = 8,
  parameter int unsigned WSEL_W    = 5,
  localparam int unsigned PBA_WORDS = (NUM_VEC + PBA_WORD_BITS - 1) / PBA_WORD_BITS,
  localparam int unsigned PAD_W     = PBA_WORDS * PBA_WORD_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_VEC-1:0]  set_i,
  input  logic [NUM_VEC-1:0]  clr_i,
  input  logic [WSEL_W-1:0]   rd_word_i,
  output logic [NUM_VEC-1:0]  pend_o,
  output logic [63:0]         rdata_o
);
  logic [NUM_VEC-1:0] pend_q;
  logic [PAD_W-1:0]   pad;

  // a new request wins over a same-cycle acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
  assign pad    = PAD_W'(pend_q);

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < PBA_WORDS; w++) begin
      if (rd_word_i == WSEL_W'(w)) rdata_o = pad[w*PBA_WORD_BITS +: PBA_WORD_BITS];
    end
  end

  p_req_latched_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  p_clear_only_on_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/msix_msg_sel.sv
module msix_msg_sel
  import msix_gate_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_VEC-1:0]        pend_i,
  input  logic [NUM_VEC-1:0]        vmask_i,
  input  logic                      fmask_i,
  input  vec_entry_t [NUM_VEC-1:0]  tbl_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [63:0]               addr_o,
  output logic [31:0]               data_o,
  output logic [NUM_VEC-1:0]        clr_o
);
  logic               valid_q;
  logic [VEC_W-1:0]   vec_q;
  logic [63:0]        addr_q;
  logic [31:0]        data_q;
  logic               accept, free, found;
  logic [NUM_VEC-1:0] elig;
  logic [VEC_W-1:0]   pick;

  assign accept = valid_q && ready_i;
  assign free   = !valid_q || ready_i;

  always_comb begin
    clr_o = '0;
    if (accept) clr_o[vec_q] = 1'b1;
  end

  // the vector leaving this cycle is not a candidate
  assign elig = pend_i & ~vmask_i & ~clr_o & {NUM_VEC{~fmask_i}};

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        pick  = VEC_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (free) begin
      valid_q <= found;
      if (found) begin
        vec_q  <= pick;
        addr_q <= {tbl_i[pick].addr_hi, tbl_i[pick].addr_lo};
        data_q <= tbl_i[pick].data;
      end
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  p_hold_under_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(vec_q) && $stable(addr_q) && $stable(data_q)));

  p_fmask_blocks_new_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free && fmask_i) |=> !valid_q);
endmodule

// File: rtl/msix_gate.sv
module msix_gate
  import msix_gate_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned OFF_W  = $clog2(NUM_VEC) + 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_space_i,
  input  logic [OFF_W-1:0]   reg_off_i,
  input  logic               reg_wide_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [VEC_W-1:0]   msg_vec_o,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  localparam int unsigned WSEL_W = OFF_W - 3;

  reg_space_e               space;
  vec_entry_t [NUM_VEC-1:0] tbl;
  logic [NUM_VEC-1:0]       vmask, pend, clr;
  logic [63:0]              tbl_rdata, pba_rdata;
  logic                     fmask_q;

  assign space = reg_space_e'(reg_space_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              fmask_q <= 1'b0;
    else if (reg_wr_i && space == SPACE_CTRL) fmask_q <= reg_wdata_i[FMASK_BIT];
  end

  msix_vec_table #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i && space == SPACE_TABLE),
    .wide_i  (reg_wide_i),
    .off_i   (reg_off_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (tbl_rdata),
    .tbl_o   (tbl),
    .vmask_o (vmask)
  );

  msix_pend_array #(.NUM_VEC(NUM_VEC), .WSEL_W(WSEL_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_i),
    .clr_i     (clr),
    .rd_word_i (reg_off_i[OFF_W-1:3]),
    .pend_o    (pend),
    .rdata_o   (pba_rdata)
  );

  msix_msg_sel #(.NUM_VEC(NUM_VEC)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .vmask_i (vmask),
    .fmask_i (fmask_q),
    .tbl_i   (tbl),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .vec_o   (msg_vec_o),
    .addr_o  (msg_addr_o),
    .data_o  (msg_data_o),
    .clr_o   (clr)
  );

  always_comb begin
    unique case (space)
      SPACE_TABLE: reg_rdata_o = tbl_rdata;
      SPACE_PBA:   reg_rdata_o = pba_rdata;
      SPACE_CTRL:  reg_rdata_o = 64'(fmask_q) << FMASK_BIT;
      default:     reg_rdata_o = '0;
    endcase
  end

  p_offer_is_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> pend[msg_vec_o]);
endmodule

// File: tb/tb_msix_gate.sv
module tb_msix_gate;
  localparam int NV  = 8;
  localparam int VW  = $clog2(NV);
  localparam int OW  = $clog2(NV) + 5;

  typedef struct {
    int          vec;
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NV-1:0]   irq = '0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_space = 2'd0;
  logic [OW-1:0]   reg_off = '0;
  logic            reg_wide = 1'b0;
  logic [63:0]     reg_wdata = '0;
  logic [63:0]     reg_rdata;
  logic            msg_valid;
  logic            msg_ready = 1'b1;
  logic [VW-1:0]   msg_vec;
  logic [63:0]     msg_addr;
  logic [31:0]     msg_data;

  int n_chk = 0, n_bad = 0, n_seen = 0;
  msg_t exp_q[$];
  logic [31:0] e_lo [NV];
  logic [31:0] e_hi [NV];
  logic [31:0] e_dat[NV];

  always #2 clk = ~clk;

  msix_gate #(.NUM_VEC(NV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_wr_i(reg_wr), .reg_space_i(reg_space), .reg_off_i(reg_off),
    .reg_wide_i(reg_wide), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_vec_o(msg_vec),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input int off, input logic wide, input logic [63:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_space = sp; reg_off = OW'(off); reg_wide = wide; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] sp, input int off, input logic wide,
                    input logic [63:0] exp);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_space = sp; reg_off = OW'(off); reg_wide = wide;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [NV-1:0] bits);
    @(posedge clk); #1 irq = bits;
    @(posedge clk); #1 irq = '0;
  endtask

  task automatic expect_msg(input int v);
    msg_t m;
    m.vec = v; m.addr = {e_hi[v], e_lo[v]}; m.data = e_dat[v];
    exp_q.push_back(m);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  logic          stall_prev = 1'b0;
  logic [VW-1:0] p_vec;
  logic [63:0]   p_addr;
  logic [31:0]   p_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        n_chk++;
        if (!(msg_valid && msg_vec == p_vec && msg_addr == p_addr && msg_data == p_data)) begin
          n_bad++;
          $display("FAIL R10 hold actual=%b/%0d/%h expected=1/%0d/%h", msg_valid, msg_vec, msg_addr, p_vec, p_addr);
        end
      end
      stall_prev = msg_valid && !msg_ready;
      p_vec = msg_vec; p_addr = msg_addr; p_data = msg_data;
      if (msg_valid && msg_ready) begin
        msg_t m;
        n_seen++;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R5/R8 unexpected message actual=vec %0d expected=none", msg_vec);
        end else begin
          m = exp_q.pop_front();
          if (int'(msg_vec) != m.vec || msg_addr != m.addr || msg_data != m.data) begin
            n_bad++;
            $display("FAIL R6/R9 message actual=%0d/%h/%h expected=%0d/%h/%h",
                     msg_vec, msg_addr, msg_data, m.vec, m.addr, m.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 valid", 64'(msg_valid), 64'd0);
    rd("R1 mask v0", 2'd0, 16*0 + 12, 1'b0, 64'd1);
    rd("R1 mask v7", 2'd0, 16*7 + 12, 1'b0, 64'd1);
    rd("R1 fmask", 2'd2, 0, 1'b0, 64'd0);
    rd("R1 pba", 2'd1, 0, 1'b1, 64'd0);

    // program entries: R2 narrow for even, R3 wide for odd
    for (int v = 0; v < NV; v++) begin
      e_lo[v] = 32'hFEE0_0000 + 32'(v * 16);
      e_hi[v] = 32'h0000_0A00 + 32'(v);
      e_dat[v] = 32'h100 + 32'(v);
      if (v % 2 == 0) begin
        wr(2'd0, 16*v + 0, 1'b0, 64'(e_lo[v]));
        wr(2'd0, 16*v + 4, 1'b0, 64'(e_hi[v]));
        wr(2'd0, 16*v + 8, 1'b0, 64'(e_dat[v]));
      end else begin
        wr(2'd0, 16*v + 0, 1'b1, {e_hi[v], e_lo[v]});
        wr(2'd0, 16*v + 8, 1'b1, {32'h1, e_dat[v]});
      end
    end
    rd("R2 lo v2", 2'd0, 16*2 + 0, 1'b0, 64'(e_lo[2]));
    rd("R2 hi v2", 2'd0, 16*2 + 4, 1'b0, 64'(e_hi[2]));
    rd("R2 data v2", 2'd0, 16*2 + 8, 1'b0, 64'(e_dat[2]));
    rd("R3 wide addr v3", 2'd0, 16*3 + 0, 1'b1, {e_hi[3], e_lo[3]});
    rd("R3 wide data/ctl v3", 2'd0, 16*3 + 8, 1'b1, {32'h1, e_dat[3]});
    wr(2'd0, 16*4 + 12, 1'b0, 64'hFFFF_FFFF);
    rd("R2 ctl only bit0 v4", 2'd0, 16*4 + 12, 1'b0, 64'd1);

    // R4 ignored writes and zero reads
    wr(2'd0, 16*0 + 4, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(2'd0, 16*0 + 2, 1'b0, 64'h1234_5678);
    rd("R4 v0 lo unchanged", 2'd0, 16*0 + 0, 1'b0, 64'(e_lo[0]));
    rd("R4 v0 hi unchanged", 2'd0, 16*0 + 4, 1'b0, 64'(e_hi[0]));
    rd("R4 odd offset reads 0", 2'd0, 16*0 + 2, 1'b0, 64'd0);
    wr(2'd0, 16*9 + 0, 1'b0, 64'h5555_5555);
    rd("R4 out of range reads 0", 2'd0, 16*9 + 0, 1'b0, 64'd0);
    wr(2'd1, 0, 1'b1, 64'hFF);
    rd("R4 pba write ignored", 2'd1, 0, 1'b1, 64'd0);
    wr(2'd3, 0, 1'b1, 64'hFFFF);
    rd("R4 space3 ignored fmask", 2'd2, 0, 1'b0, 64'd0);

    // R5 masked request -> pending, no message
    seen0 = n_seen;
    pulse(8'h04);
    settle(6);
    chk("R5 no message", 64'(n_seen - seen0), 64'd0);
    rd("R5 pba bit2", 2'd1, 0, 1'b1, 64'h04);

    // R7 unmask with pending -> send
    expect_msg(2);
    wr(2'd0, 16*2 + 12, 1'b0, 64'd0);
    settle(6);
    chk("R7 delivered", 64'(exp_q.size()), 64'd0);
    rd("R7 pba cleared", 2'd1, 0, 1'b1, 64'd0);

    // R6 unmasked request
    wr(2'd0, 16*3 + 12, 1'b0, 64'd0);
    expect_msg(3);
    pulse(8'h08);
    settle(6);
    chk("R6 delivered", 64'(exp_q.size()), 64'd0);

    // R10/R11 stall, pending visible, repeat request merges
    @(posedge clk); #1 msg_ready = 1'b0;
    seen0 = n_seen;
    pulse(8'h08);
    settle(3);
    chk("R10 offered while stalled", 64'(msg_valid), 64'd1);
    rd("R10 pending until accept", 2'd1, 0, 1'b1, 64'h08);
    pulse(8'h08);
    settle(3);
    expect_msg(3);
    @(posedge clk); #1 msg_ready = 1'b1;
    settle(6);
    chk("R11 single message", 64'(n_seen - seen0), 64'd1);
    rd("R10 pba cleared after accept", 2'd1, 0, 1'b1, 64'd0);

    // R8/R9 function mask and replay
    wr(2'd2, 0, 1'b0, 64'h4000);
    rd("R9 fmask reads bit14", 2'd2, 0, 1'b0, 64'h4000);
    wr(2'd0, 16*1 + 12, 1'b0, 64'd0);
    wr(2'd0, 16*6 + 12, 1'b0, 64'd0);
    seen0 = n_seen;
    pulse(8'h40);
    pulse(8'h0A);
    pulse(8'hA0);
    e_dat[5] = 32'h205;
    wr(2'd0, 16*5 + 8, 1'b1, {32'h0, e_dat[5]});
    settle(6);
    chk("R8 no message under fmask", 64'(n_seen - seen0), 64'd0);
    rd("R8 pba kept", 2'd1, 0, 1'b1, 64'hEA);
    expect_msg(1); expect_msg(3); expect_msg(5); expect_msg(6);
    wr(2'd2, 0, 1'b0, 64'h0);
    @(posedge clk); #1 msg_ready = 1'b0;
    settle(2);
    @(posedge clk); #1 msg_ready = 1'b1;
    settle(12);
    chk("R9 replay count", 64'(n_seen - seen0), 64'd4);
    chk("R9 all replayed", 64'(exp_q.size()), 64'd0);
    rd("R9 masked stays pending", 2'd1, 0, 1'b1, 64'h80);

    // R3 wide unmask at +8 with fmask clear
    e_dat[7] = 32'h307;
    expect_msg(7);
    wr(2'd0, 16*7 + 8, 1'b1, {32'h0, e_dat[7]});
    settle(6);
    chk("R3 wide unmask delivered", 64'(exp_q.size()), 64'd0);
    rd("R3 pba empty", 2'd1, 0, 1'b1, 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule